// File: doc/BRIEF.md
# Unaligned Access Cycle Splitter

This block sits between a processor's load/store unit and a 16-bit external data bus. It accepts one memory request at a time. A request holds a byte address, an operand size of word, double-word or quad-word, and either write data or a read path. The block breaks the request into the bus cycles the narrow bus needs. For each cycle it presents an address, an active-low high-lane enable and address bit 0. It places operand bytes on the low lane (bits 7:0) and the high lane (bits 15:8). On reads it collects the returned lanes back into operand order in a 64-bit result.

The split follows a fixed pattern. An even address is served with full 16-bit cycles, and only a final lone byte uses a low-lane byte cycle. An odd address starts with a high-lane byte cycle at the odd address, continues with full cycles on even addresses, and ends with a low-lane byte cycle when one byte remains. A quad-word is handled as two independent four-byte halves at A and A+4. Between the halves the block drops its cycle request for one clock, so other bus masters, such as instruction prefetch or slave traffic, can take the bus. Each cycle is held until the bus side answers with a done strobe. A single completion pulse marks the end of the whole request.

Top module: `unaligned_splitter`

## Requirements
- R1: After reset, reqReady is 1 and busy, cycReq and doneP are 0.
- R2: A word at an even address uses one cycle at A with cycHbeN=0 and cycA0=0. Operand byte 0 goes on the low lane and byte 1 on the high lane.
- R3: A word at an odd address uses two cycles. The first is at A with cycHbeN=0 and cycA0=1, carrying byte 0 on the high lane. The second is at A+1 with cycHbeN=1 and cycA0=0, carrying byte 1 on the low lane.
- R4: A double-word at an even address uses two full cycles, at A and A+2, both with cycHbeN=0. The first carries bytes 0 (low) and 1 (high), and the second carries bytes 2 (low) and 3 (high).
- R5: A double-word at an odd address uses three cycles. The first is a high-lane cycle at A with byte 0. The second is a full cycle at A+1 with byte 1 low and byte 2 high. The third is a low-lane cycle at A+3 (cycHbeN=1) with byte 3.
- R6: A quad-word (reqSize=2, and 3 behaves the same) runs the double-word pattern of R4 or R5 twice: first at A for bytes 0 to 3, then at A+4 for bytes 4 to 7.
- R7: Between the two halves of a quad-word, cycReq is 0 for exactly one clock while busy stays 1. Requests of other sizes never drop cycReq before completion.
- R8: On writes, a lane that carries no operand byte is driven to zero. On reads, cycWdata is zero in every cycle. cycWrite is 1 only during cycles of a write request.
- R9: On reads, each lane that carries a byte is stored at that byte's operand position, and lanes that carry no byte are ignored. rdData holds the assembled operand, with byte k at bits 8k+7:8k, while doneP is 1.
- R10: doneP pulses high for exactly one clock, in the clock after the cycDone of the final cycle. After that the block is idle, and no further cycle is issued.
- R11: While cycReq is 1 and cycDone is 0, the cycle's address, enables and write data stay unchanged.
- R12: reqValid is ignored while busy is 1. A request is taken only when reqReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | New request present |
| reqReady | output | 1 | Block is idle and will take a request |
| reqAddr | input | ADDR_W | Byte address of the operand |
| reqSize | input | 2 | 0 word, 1 double-word, 2 or 3 quad-word |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqWdata | input | 64 | Write operand, byte k at bits 8k+7:8k |
| busy | output | 1 | A request sequence is in progress |
| doneP | output | 1 | One-clock completion pulse |
| rdData | output | 64 | Assembled read operand |
| cycReq | output | 1 | Bus cycle requested (held until cycDone) |
| cycDone | input | 1 | Bus side completes the current cycle |
| cycAddr | output | ADDR_W | Byte address of the cycle |
| cycHbeN | output | 1 | Active-low high-lane enable |
| cycA0 | output | 1 | Address bit 0 of the cycle |
| cycWrite | output | 1 | Cycle is a write |
| cycWdata | output | 16 | Write lanes, high lane at bits 15:8 |
| cycRdata | input | 16 | Returned read lanes |

## Verification
Requests are tried at even and odd addresses for every size, both as reads and as writes. This tells the full-word pattern apart from the odd-byte, word, trailing-byte pattern, and it shows that the lane steering of each operand byte is correct. Quad-word requests at both parities show that the second half restarts its pattern at A+4 after a one-clock release. The bus side returns a marker value on lanes that carry no byte, so any read byte taken from the wrong lane shows up in the result. Some runs delay cycDone, which checks that a cycle is held steady. A competing request is kept on the input throughout each sequence, which checks that it has no effect.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

  localparam int OP_BYTES = 8;
  localparam int OP_W     = OP_BYTES * 8;
  localparam int LANE_W   = 16;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       load;
    logic       capture;
    logic       active;
    logic       half;
    logic [1:0] step;
  } ctlStrobe_t;

  // shape of one bus cycle inside a four-byte half
  typedef struct packed {
    logic [1:0] addrOff;
    logic       hbeN;
    logic       lowUsed;
    logic       highUsed;
    logic [1:0] lowIdx;
    logic [1:0] highIdx;
  } cycDesc_t;

  function automatic cycDesc_t describe(logic odd, logic isWord, logic [1:0] step);
    cycDesc_t d;
    d = '0;
    if (odd) begin
      case (step)
        2'd0: begin
          d.addrOff = 2'd0; d.hbeN = 1'b0; d.highUsed = 1'b1; d.highIdx = 2'd0;
        end
        2'd1: begin
          d.addrOff = 2'd1; d.lowUsed = 1'b1; d.lowIdx = 2'd1;
          d.hbeN = isWord;
          d.highUsed = !isWord; d.highIdx = 2'd2;
        end
        default: begin
          d.addrOff = 2'd3; d.hbeN = 1'b1; d.lowUsed = 1'b1; d.lowIdx = 2'd3;
        end
      endcase
    end else begin
      d.addrOff  = {step[0], 1'b0};
      d.hbeN     = 1'b0;
      d.lowUsed  = 1'b1;
      d.highUsed = 1'b1;
      d.lowIdx   = {step[0], 1'b0};
      d.highIdx  = {step[0], 1'b1};
    end
    return d;
  endfunction

  function automatic logic [1:0] lastStep(logic odd, logic isWord);
    if (odd) return isWord ? 2'd1 : 2'd2;
    return isWord ? 2'd0 : 2'd1;
  endfunction

endpackage

// File: rtl/splitter_ctrl.sv
module splitter_ctrl
  import splitter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqSize,
  input  logic       reqOdd,
  input  logic       cycDone,
  output ctlStrobe_t strobe,
  output logic       cycReq,
  output logic       busy,
  output logic       reqReady,
  output logic       doneP
);

  seqState_e  state;
  logic [1:0] step;
  logic       half;
  logic [1:0] sizeLat;
  logic       oddLat;
  logic       accept;
  logic       isWord;
  logic       isQuad;
  logic       atLast;
  logic       advance;

  assign isWord   = (sizeLat == 2'd0);
  assign isQuad   = sizeLat[1];
  assign atLast   = (step == lastStep(oddLat, isWord));
  assign reqReady = (state == S_IDLE);
  assign busy     = (state != S_IDLE);
  assign cycReq   = (state == S_RUN);
  assign accept   = reqReady && reqValid;
  assign advance  = cycReq && cycDone;

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.capture = advance;
    strobe.active  = cycReq;
    strobe.half    = half;
    strobe.step    = step;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      step    <= '0;
      half    <= 1'b0;
      sizeLat <= '0;
      oddLat  <= 1'b0;
      doneP   <= 1'b0;
    end else begin
      doneP <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            state   <= S_RUN;
            step    <= '0;
            half    <= 1'b0;
            sizeLat <= reqSize;
            oddLat  <= reqOdd;
          end
        end
        S_RUN: begin
          if (advance) begin
            if (!atLast) begin
              step <= step + 2'd1;
            end else if (isQuad && !half) begin
              state <= S_GAP;
              step  <= '0;
              half  <= 1'b1;
            end else begin
              state <= S_IDLE;
              doneP <= 1'b1;
            end
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end

endmodule

// File: rtl/splitter_datapath.sv
module splitter_datapath
  import splitter_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [OP_W-1:0]   reqWdata,
  input  logic [LANE_W-1:0] cycRdata,
  output logic [ADDR_W-1:0] cycAddr,
  output logic              cycHbeN,
  output logic              cycA0,
  output logic              cycWrite,
  output logic [LANE_W-1:0] cycWdata,
  output logic [OP_W-1:0]   rdData
);

  localparam int POS_W = $clog2(OP_BYTES);

  logic [ADDR_W-1:0] baseAddr;
  logic [OP_W-1:0]   wBuf;
  logic [OP_W-1:0]   rdAsm;
  logic              isWrite;
  logic              isWord;
  cycDesc_t          desc;
  logic [POS_W-1:0]  lowPos;
  logic [POS_W-1:0]  highPos;

  assign desc    = describe(baseAddr[0], isWord, strobe.step);
  assign lowPos  = {strobe.half, desc.lowIdx};
  assign highPos = {strobe.half, desc.highIdx};
  assign cycAddr = baseAddr + ADDR_W'({strobe.half, 2'b00}) + ADDR_W'(desc.addrOff);
  assign cycA0   = cycAddr[0];
  assign cycHbeN = strobe.active ? desc.hbeN : 1'b1;
  assign cycWrite = strobe.active && isWrite;
  assign rdData  = rdAsm;

  always_comb begin
    cycWdata = '0;
    if (cycWrite) begin
      if (desc.lowUsed)  cycWdata[7:0]  = wBuf[{lowPos, 3'b000} +: 8];
      if (desc.highUsed) cycWdata[15:8] = wBuf[{highPos, 3'b000} +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      wBuf     <= '0;
      rdAsm    <= '0;
      isWrite  <= 1'b0;
      isWord   <= 1'b0;
    end else if (strobe.load) begin
      baseAddr <= reqAddr;
      wBuf     <= reqWdata;
      rdAsm    <= '0;
      isWrite  <= reqWrite;
      isWord   <= (reqSize == 2'd0);
    end else if (strobe.capture && !isWrite) begin
      if (desc.lowUsed)  rdAsm[{lowPos, 3'b000} +: 8]  <= cycRdata[7:0];
      if (desc.highUsed) rdAsm[{highPos, 3'b000} +: 8] <= cycRdata[15:8];
    end
  end

endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import splitter_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [63:0]       reqWdata,
  output logic              busy,
  output logic              doneP,
  output logic [63:0]       rdData,
  output logic              cycReq,
  input  logic              cycDone,
  output logic [ADDR_W-1:0] cycAddr,
  output logic              cycHbeN,
  output logic              cycA0,
  output logic              cycWrite,
  output logic [15:0]       cycWdata,
  input  logic [15:0]       cycRdata
);

  ctlStrobe_t strobe;

  splitter_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqSize  (reqSize),
    .reqOdd   (reqAddr[0]),
    .cycDone  (cycDone),
    .strobe   (strobe),
    .cycReq   (cycReq),
    .busy     (busy),
    .reqReady (reqReady),
    .doneP    (doneP)
  );

  splitter_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .cycRdata (cycRdata),
    .cycAddr  (cycAddr),
    .cycHbeN  (cycHbeN),
    .cycA0    (cycA0),
    .cycWrite (cycWrite),
    .cycWdata (cycWdata),
    .rdData   (rdData)
  );

endmodule

// File: rtl/splitter_chk.sv
module splitter_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              busy,
  input logic              doneP,
  input logic              cycReq,
  input logic              cycDone,
  input logic [ADDR_W-1:0] cycAddr,
  input logic              cycHbeN,
  input logic              cycA0,
  input logic              cycWrite,
  input logic [15:0]       cycWdata
);

  // R11
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycReq && !cycDone) |=> (cycReq && $stable(cycAddr) && $stable(cycHbeN) && $stable(cycWdata)));

  // R3
  odd_cycle_high_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycReq && cycA0) |-> !cycHbeN);

  // R8
  unused_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycReq && cycHbeN) |-> (cycWdata[15:8] == 8'h00));

  // R8
  read_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycReq && !cycWrite) |-> (cycWdata == 16'h0000));

  // R7
  gap_one_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cycReq) |=> cycReq);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> (reqReady && !cycReq));

  // R10
  done_after_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneP) |-> $past(cycReq && cycDone));

endmodule

bind unaligned_splitter splitter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .busy     (busy),
  .doneP    (doneP),
  .cycReq   (cycReq),
  .cycDone  (cycDone),
  .cycAddr  (cycAddr),
  .cycHbeN  (cycHbeN),
  .cycA0    (cycA0),
  .cycWrite (cycWrite),
  .cycWdata (cycWdata)
);

// File: tb/unaligned_splitter_tb_top.sv
module unaligned_splitter_tb_top;

  localparam int ADDR_W = 24;

  typedef struct packed {
    logic [1:0]        sz;
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [63:0]       data;
    logic              slow;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 24'h000100, 1'b1, 64'h0000_0000_0000_B2A1, 1'b0},
    '{2'd0, 24'h000233, 1'b1, 64'h0000_0000_0000_C4D3, 1'b0},
    '{2'd0, 24'h000415, 1'b0, 64'h0000_0000_0000_5E6F, 1'b1},
    '{2'd0, 24'h000420, 1'b0, 64'h0000_0000_0000_7788, 1'b0},
    '{2'd1, 24'h001000, 1'b0, 64'h0000_0000_1234_5678, 1'b0},
    '{2'd1, 24'h001001, 1'b1, 64'h0000_0000_9ABC_DEF0, 1'b0},
    '{2'd1, 24'h0020FF, 1'b0, 64'h0000_0000_0BAD_F00D, 1'b1},
    '{2'd2, 24'h003000, 1'b1, 64'h0102_0304_0506_0708, 1'b0},
    '{2'd2, 24'h004003, 1'b0, 64'hF1E2_D3C4_B5A6_9788, 1'b0},
    '{2'd3, 24'h005007, 1'b1, 64'h1122_3344_5566_7788, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqSize = '0;
  logic              reqWrite = 1'b0;
  logic [63:0]       reqWdata = '0;
  logic              busy;
  logic              doneP;
  logic [63:0]       rdData;
  logic              cycReq;
  logic              cycDone = 1'b0;
  logic [ADDR_W-1:0] cycAddr;
  logic              cycHbeN;
  logic              cycA0;
  logic              cycWrite;
  logic [15:0]       cycWdata;
  logic [15:0]       cycRdata = '0;

  int total = 0;
  int bad = 0;
  int cycCount = 0;

  always #5 clk = ~clk;

  unaligned_splitter #(.ADDR_W(ADDR_W)) dut_i (.*);

  always @(posedge clk) begin
    cycCount <= cycCount + 1;
    if (cycCount > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=100000", cycCount);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected cycle list, built by walking operand bytes through addresses
  task automatic runOne(input vec_t v);
    logic [ADDR_W-1:0] eAddr [8];
    logic              eHbe [8];
    logic              eLowU [8];
    logic              eHighU [8];
    int                eLowB [8];
    int                eHighB [8];
    int n = 0;
    int halves = v.sz[1] ? 2 : 1;
    int span = (v.sz == 2'd0) ? 2 : 4;
    int idx = 0;
    int gaps = 0;
    int guard = 0;
    bit waited = 0;
    string tag;
    logic [ADDR_W-1:0] a;
    logic [7:0] lowB;
    logic [7:0] highB;

    if (v.sz[1]) tag = "R6";
    else if (v.sz == 2'd0) tag = v.addr[0] ? "R3" : "R2";
    else tag = v.addr[0] ? "R5" : "R4";

    for (int h = 0; h < halves; h++) begin
      int k = 0;
      while (k < span) begin
        a = v.addr + ADDR_W'(h * 4 + k);
        eAddr[n] = a; eLowU[n] = 0; eHighU[n] = 0; eLowB[n] = 0; eHighB[n] = 0;
        if (a[0]) begin
          eHbe[n] = 0; eHighU[n] = 1; eHighB[n] = h * 4 + k; k = k + 1;
        end else if (k + 1 < span) begin
          eHbe[n] = 0; eLowU[n] = 1; eHighU[n] = 1;
          eLowB[n] = h * 4 + k; eHighB[n] = h * 4 + k + 1; k = k + 2;
        end else begin
          eHbe[n] = 1; eLowU[n] = 1; eLowB[n] = h * 4 + k; k = k + 1;
        end
        n = n + 1;
      end
    end

    reqValid = 1'b1; reqAddr = v.addr; reqSize = v.sz;
    reqWrite = v.wr; reqWdata = v.data;
    @(posedge clk);
    @(negedge clk);
    // competing request held during the whole sequence (R12)
    reqAddr = 24'h555555; reqSize = 2'd1; reqWrite = ~v.wr; reqWdata = '1;

    while (guard < 100) begin
      guard = guard + 1;
      cycDone = 1'b0;
      cycRdata = 16'hEEEE;
      if (doneP) break;
      if (cycReq) begin
        if (idx >= n) begin
          check({tag, " R10 extra cycle"}, 64'(idx), 64'(n));
        end else begin
          string t2;
          t2 = waited ? {tag, " R11"} : tag;
          check({t2, " addr"}, 64'(cycAddr), 64'(eAddr[idx]));
          check({t2, " hbeN"}, 64'(cycHbeN), 64'(eHbe[idx]));
          check({t2, " a0"}, 64'(cycA0), 64'(eAddr[idx][0]));
          check({t2, " R8 write flag"}, 64'(cycWrite), 64'(v.wr));
          lowB  = eLowU[idx]  ? v.data[eLowB[idx]*8 +: 8]  : 8'h00;
          highB = eHighU[idx] ? v.data[eHighB[idx]*8 +: 8] : 8'h00;
          if (v.wr) check({t2, " R8 lanes"}, 64'(cycWdata), 64'({highB, lowB}));
          else      check({t2, " R8 read lanes"}, 64'(cycWdata), 64'h0);
          if (v.slow && !waited) begin
            waited = 1;
          end else begin
            waited = 0;
            cycDone = 1'b1;
            cycRdata = {eHighU[idx] ? highB : 8'hEE, eLowU[idx] ? lowB : 8'hEE};
            idx = idx + 1;
          end
        end
      end else if (busy) begin
        gaps = gaps + 1;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;

    check({tag, " R10 doneP seen"}, 64'(doneP), 64'h1);
    check({tag, " R10 R12 cycle count"}, 64'(idx), 64'(n));
    check({tag, " R7 gap count"}, 64'(gaps), v.sz[1] ? 64'h1 : 64'h0);
    if (!v.wr) check({tag, " R9 rdData"}, rdData, v.data);
    check({tag, " R10 idle"}, 64'({reqReady, busy}), 64'b10);
    @(negedge clk);
    check({tag, " R10 single pulse"}, 64'({doneP, cycReq}), 64'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    check("R1 reset reqReady", 64'(reqReady), 64'h1);
    check("R1 reset busy", 64'(busy), 64'h0);
    check("R1 reset cycReq", 64'(cycReq), 64'h0);
    check("R1 reset doneP", 64'(doneP), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'({reqReady, busy, cycReq, doneP}), 64'b1000);

    for (int i = 0; i < NV; i++) runOne(VECS[i]);

    // back-to-back: a request on the same clock as the previous doneP (R12)
    reqValid = 1'b1; reqAddr = 24'h000600; reqSize = 2'd0; reqWrite = 1'b1;
    reqWdata = 64'h00AB;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 R12 accept", 64'({busy, cycReq, cycAddr}), {2'b11, 24'h000600});
    cycDone = 1'b1;
    @(negedge clk);
    cycDone = 1'b0;
    check("R10 pulse", 64'(doneP), 64'h1);
    reqValid = 1'b1; reqAddr = 24'h000701; reqSize = 2'd0; reqWrite = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R3 R12 accept at doneP", 64'({cycReq, cycAddr, cycHbeN}), {1'b1, 24'h000701, 1'b0});
    cycDone = 1'b1; cycRdata = 16'h3CEE;
    @(negedge clk);
    check("R3 second cycle", 64'({cycAddr, cycHbeN}), {24'h000702, 1'b1});
    cycRdata = 16'hEE4D;
    @(negedge clk);
    cycDone = 1'b0;
    check("R9 odd word read", rdData, 64'h4D3C);

    // reset in mid-sequence returns to idle (R1)
    reqValid = 1'b1; reqAddr = 24'h000801; reqSize = 2'd2; reqWrite = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset mid-run", 64'({reqReady, busy, cycReq, doneP}), 64'b1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule